// File: doc/BRIEF.md
# Privilege-Aware Exception Vector Router

This block decides, for each exception request, which privilege context takes the exception and which handler address the fetch unit must jump to. It keeps three 32-byte-aligned vector base registers: one for the guest kernel and user levels, one for the hypervisor level, and one for the secure monitor. The handler address is the chosen base plus a slot offset taken from a fixed eight-entry table, in which the slot formerly left reserved now carries the hypervisor call.

Alongside the routing, the block guards writes to the base registers by the privilege of the current mode, holds a hypervisor-enable bit that only secure software can change, and captures a syndrome word whenever a hypervisor call or a trapped sensitive instruction moves a guest kernel into hypervisor mode. Instruction decode and pipeline flush live elsewhere; the block only sees the current mode, an exception strobe with its type, a trap strobe with its class, and register write requests. Every result is registered and appears one clock after the request.

Top module: `exc_vector_router`

## Requirements
- R1: Mode codes on `cur_mode`/`tgt_mode` are 0 guest user, 1 guest kernel, 2 hypervisor, 3 secure user, 4 secure kernel, 5 monitor. Exception type codes are 0 reset, 1 undefined, 2 supervisor call, 3 prefetch abort, 4 data abort, 5 hypervisor call, 6 IRQ, 7 FIQ, and the vector offset is 4 times the code. A non-reset, non-hypervisor-call exception from mode 0 or 1 targets mode 1 at guest base plus offset.
- R2: A non-reset exception from a secure mode (3, 4, 5) targets mode 5 at monitor base plus offset. A reset-type request from any mode targets mode 5 at monitor base plus 0x00.
- R3: A hypervisor call from mode 1 while the hypervisor level is enabled targets mode 2 at hypervisor base plus 0x14 and loads the syndrome with class 0x12 in bits 21:16 and `hvc_imm` in bits 15:0.
- R4: A hypervisor call made while the hypervisor level is disabled, or from mode 0, or from a secure mode, is handled as an undefined instruction (offset 0x04) in the context that mode would normally use.
- R5: Any non-reset exception raised while in mode 2 stays in mode 2 at hypervisor base plus offset, with a hypervisor call from mode 2 going to offset 0x14.
- R6: `hyp_on` is 0 after reset; a write of `hen_val` through `hen_wr` takes effect only from mode 4 or 5 and is ignored from every other mode.
- R7: A trap request in mode 1 while `hyp_on` is 1 targets mode 2 at hypervisor base plus 0x14 and loads the syndrome with `trap_ec` in bits 21:16 and zero in bits 15:0; in any other case the trap request is ignored and produces no vector.
- R8: Base select codes are 0 guest, 1 hypervisor, 2 monitor. The monitor base is writable only from mode 5, the hypervisor base only from modes 2 or 5, the guest base from any mode except 0 and 3; select 3 is never legal. An illegal write leaves every base unchanged and, one clock later, pulses `access_fault` for one cycle together with a vector routed as an undefined instruction from the current mode.
- R9: The low five bits of every base read as zero whatever was written; `rd_base` shows the base picked by `rd_sel` (codes as in R8, 3 reads zero) one clock after the select, using the value before any write at that same edge.
- R10: The syndrome is zero after reset and changes only on a hypervisor-call or trap entry into mode 2; all other exceptions, including those taken in mode 2, leave it unchanged.
- R11: `vec_valid`, `tgt_mode`, `vec_addr` and `access_fault` are registered, appear exactly one clock after the request, and are zero during and straight after reset.
- R12: When several sources request in the same cycle, a reset-type exception wins, then an illegal write fault, then any other exception request, then a trap request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_mode | input | 3 | Current mode code (R1) |
| exc_req | input | 1 | Exception request strobe |
| exc_type | input | 3 | Exception type code (R1) |
| hvc_imm | input | 16 | Immediate of the hypervisor call |
| trap_req | input | 1 | Sensitive instruction flagged as trapping |
| trap_ec | input | 6 | Class recorded for a trap |
| wr_en | input | 1 | Base register write request |
| wr_sel | input | 2 | Base register select (R8) |
| wr_data | input | 32 | Write data |
| hen_wr | input | 1 | Hypervisor enable write request |
| hen_val | input | 1 | New hypervisor enable value |
| rd_sel | input | 2 | Base register read select |
| vec_valid | output | 1 | Vector outputs valid this cycle |
| tgt_mode | output | 3 | Mode that takes the exception |
| vec_addr | output | 32 | Handler address |
| access_fault | output | 1 | Illegal base write pulse |
| syndrome | output | 22 | Class and immediate of the last hypervisor entry |
| hyp_on | output | 1 | Hypervisor level enabled |
| rd_base | output | 32 | Registered base readout |

## Verification
On every cycle the assertions check that a fault always comes with an undefined-instruction vector, that hypervisor mode is only targeted when the level was enabled or already active, that the syndrome moves only with a hypervisor entry, that a request always yields a vector one clock later, that illegal monitor writes leave that base alone, and that the enable bit only rises from secure code. The exact handler addresses, the per-mode context choice, the alignment masking on readback, the priority among simultaneous requests and the treatment of a hypervisor call as undefined can only be shown by the bench scenarios comparing against its own model.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;
  localparam logic [2:0] M_NS_USR = 3'd0;
  localparam logic [2:0] M_NS_KRN = 3'd1;
  localparam logic [2:0] M_HYP    = 3'd2;
  localparam logic [2:0] M_S_USR  = 3'd3;
  localparam logic [2:0] M_S_KRN  = 3'd4;
  localparam logic [2:0] M_MON    = 3'd5;

  localparam logic [2:0] X_RESET = 3'd0;
  localparam logic [2:0] X_UNDEF = 3'd1;
  localparam logic [2:0] X_HVC   = 3'd5;

  localparam logic [1:0] B_GUEST = 2'd0;
  localparam logic [1:0] B_HYP   = 2'd1;
  localparam logic [1:0] B_MON   = 2'd2;

  localparam int NUM_BASE = 3;

  function automatic logic is_secure(input logic [2:0] m);
    return m >= M_S_USR;
  endfunction
endpackage

// File: rtl/exc_vec_bank.sv
module exc_vec_bank
  import exc_vec_pkg::*;
#(
  parameter int AW    = 32,
  parameter int ALIGN = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    cur_mode,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          hen_wr,
  input  logic          hen_val,
  input  logic [1:0]    rd_sel,
  output logic [AW-1:0] guest_base,
  output logic [AW-1:0] hyp_base,
  output logic [AW-1:0] mon_base,
  output logic          hyp_on,
  output logic          wr_bad,
  output logic [AW-1:0] rd_base
);
  localparam int HW = AW - ALIGN;

  logic [HW-1:0] base_q [NUM_BASE];
  logic          wr_ok;
  logic          hen_q;

  always_comb begin
    unique case (wr_sel)
      B_GUEST: wr_ok = (cur_mode != M_NS_USR) && (cur_mode != M_S_USR);
      B_HYP:   wr_ok = (cur_mode == M_HYP) || (cur_mode == M_MON);
      B_MON:   wr_ok = (cur_mode == M_MON);
      default: wr_ok = 1'b0;
    endcase
  end

  assign wr_bad = wr_en && !wr_ok;

  for (genvar i = 0; i < NUM_BASE; i++) begin : g_base
    always_ff @(posedge clk) begin
      if (rst)
        base_q[i] <= '0;
      else if (wr_en && wr_ok && (wr_sel == 2'(i)))
        base_q[i] <= wr_data[AW-1:ALIGN];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      hen_q <= 1'b0;
    else if (hen_wr && ((cur_mode == M_S_KRN) || (cur_mode == M_MON)))
      hen_q <= hen_val;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_base <= '0;
    else if (rd_sel == 2'd3)
      rd_base <= '0;
    else
      rd_base <= {base_q[rd_sel], {ALIGN{1'b0}}};
  end

  assign guest_base = {base_q[0], {ALIGN{1'b0}}};
  assign hyp_base   = {base_q[1], {ALIGN{1'b0}}};
  assign mon_base   = {base_q[2], {ALIGN{1'b0}}};
  assign hyp_on     = hen_q;

  // R8: a monitor base write from any other mode leaves it unchanged
  assert_mon_guard_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_sel == B_MON) && (cur_mode != M_MON)) |=> $stable(mon_base));

  // R6: the enable bit only rises after a write from secure kernel or monitor
  assert_hyp_enable_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(hyp_on) |-> $past(hen_wr && ((cur_mode == M_S_KRN) || (cur_mode == M_MON))));
endmodule

// File: rtl/exc_vec_route.sv
module exc_vec_route
  import exc_vec_pkg::*;
#(
  parameter int AW    = 32,
  parameter int EC_W  = 6,
  parameter int IMM_W = 16
) (
  input  logic [2:0]          cur_mode,
  input  logic                exc_req,
  input  logic [2:0]          exc_type,
  input  logic [IMM_W-1:0]    hvc_imm,
  input  logic                trap_req,
  input  logic [EC_W-1:0]     trap_ec,
  input  logic [EC_W-1:0]     hvc_ec,
  input  logic                wr_bad,
  input  logic                hyp_on,
  input  logic [AW-1:0]       guest_base,
  input  logic [AW-1:0]       hyp_base,
  input  logic [AW-1:0]       mon_base,
  output logic                fire,
  output logic [2:0]          tgt,
  output logic [AW-1:0]       addr,
  output logic                syn_load,
  output logic [EC_W+IMM_W-1:0] syn_val
);
  logic [2:0]    slot;
  logic [AW-1:0] base;
  logic          use_ctx;
  logic          guest_hvc;
  logic          trap_take;

  assign guest_hvc = hyp_on && (cur_mode == M_NS_KRN);
  assign trap_take = trap_req && guest_hvc;

  always_comb begin
    fire     = 1'b0;
    slot     = X_RESET;
    use_ctx  = 1'b0;
    tgt      = M_MON;
    base     = mon_base;
    syn_load = 1'b0;
    syn_val  = '0;
    if (exc_req && (exc_type == X_RESET)) begin
      fire = 1'b1;
    end else if (wr_bad) begin
      fire    = 1'b1;
      slot    = X_UNDEF;
      use_ctx = 1'b1;
    end else if (exc_req) begin
      fire = 1'b1;
      if (exc_type == X_HVC && cur_mode != M_HYP && !guest_hvc) begin
        slot    = X_UNDEF;
        use_ctx = 1'b1;
      end else if (exc_type == X_HVC && guest_hvc) begin
        slot     = X_HVC;
        tgt      = M_HYP;
        base     = hyp_base;
        syn_load = 1'b1;
        syn_val  = {hvc_ec, hvc_imm};
      end else begin
        slot    = exc_type;
        use_ctx = 1'b1;
      end
    end else if (trap_take) begin
      fire     = 1'b1;
      slot     = X_HVC;
      tgt      = M_HYP;
      base     = hyp_base;
      syn_load = 1'b1;
      syn_val  = {trap_ec, {IMM_W{1'b0}}};
    end

    if (use_ctx) begin
      if (cur_mode == M_HYP) begin
        tgt  = M_HYP;
        base = hyp_base;
      end else if (is_secure(cur_mode)) begin
        tgt  = M_MON;
        base = mon_base;
      end else begin
        tgt  = M_NS_KRN;
        base = guest_base;
      end
    end
  end

  assign addr = base | {{(AW-5){1'b0}}, slot, 2'b00};
endmodule

// File: rtl/exc_vec_synd.sv
module exc_vec_synd #(
  parameter int SW = 22
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [SW-1:0] val,
  output logic [SW-1:0] syn
);
  always_ff @(posedge clk) begin
    if (rst)
      syn <= '0;
    else if (load)
      syn <= val;
  end
endmodule

// File: rtl/exc_vector_router.sv
module exc_vector_router
  import exc_vec_pkg::*;
#(
  parameter int AW    = 32,
  parameter int ALIGN = 5,
  parameter int EC_W  = 6,
  parameter int IMM_W = 16,
  parameter logic [EC_W-1:0] HVC_EC = 'h12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [2:0]              cur_mode,
  input  logic                    exc_req,
  input  logic [2:0]              exc_type,
  input  logic [IMM_W-1:0]        hvc_imm,
  input  logic                    trap_req,
  input  logic [EC_W-1:0]         trap_ec,
  input  logic                    wr_en,
  input  logic [1:0]              wr_sel,
  input  logic [AW-1:0]           wr_data,
  input  logic                    hen_wr,
  input  logic                    hen_val,
  input  logic [1:0]              rd_sel,
  output logic                    vec_valid,
  output logic [2:0]              tgt_mode,
  output logic [AW-1:0]           vec_addr,
  output logic                    access_fault,
  output logic [EC_W+IMM_W-1:0]   syndrome,
  output logic                    hyp_on,
  output logic [AW-1:0]           rd_base
);
  localparam int SW = EC_W + IMM_W;

  logic [AW-1:0] guest_base, hyp_base, mon_base;
  logic          wr_bad;
  logic          fire, syn_load;
  logic [2:0]    tgt;
  logic [AW-1:0] addr;
  logic [SW-1:0] syn_val;

  exc_vec_bank #(.AW(AW), .ALIGN(ALIGN)) u_bank (
    .clk(clk), .rst(rst), .cur_mode(cur_mode),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .hen_wr(hen_wr), .hen_val(hen_val), .rd_sel(rd_sel),
    .guest_base(guest_base), .hyp_base(hyp_base), .mon_base(mon_base),
    .hyp_on(hyp_on), .wr_bad(wr_bad), .rd_base(rd_base)
  );

  exc_vec_route #(.AW(AW), .EC_W(EC_W), .IMM_W(IMM_W)) u_route (
    .cur_mode(cur_mode), .exc_req(exc_req), .exc_type(exc_type),
    .hvc_imm(hvc_imm), .trap_req(trap_req), .trap_ec(trap_ec),
    .hvc_ec(HVC_EC), .wr_bad(wr_bad), .hyp_on(hyp_on),
    .guest_base(guest_base), .hyp_base(hyp_base), .mon_base(mon_base),
    .fire(fire), .tgt(tgt), .addr(addr),
    .syn_load(syn_load), .syn_val(syn_val)
  );

  exc_vec_synd #(.SW(SW)) u_synd (
    .clk(clk), .rst(rst), .load(syn_load), .val(syn_val), .syn(syndrome)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_valid    <= 1'b0;
      tgt_mode     <= M_NS_USR;
      vec_addr     <= '0;
      access_fault <= 1'b0;
    end else begin
      vec_valid    <= fire;
      tgt_mode     <= fire ? tgt : M_NS_USR;
      vec_addr     <= fire ? addr : '0;
      access_fault <= wr_bad && !(exc_req && (exc_type == X_RESET));
    end
  end

  // R8: a fault always comes with an undefined-instruction vector
  assert_fault_undef_R8: assert property (@(posedge clk) disable iff (rst)
    access_fault |-> (vec_valid && (vec_addr[4:0] == 5'h04)));

  // R3: hypervisor mode only targeted when enabled or already there
  assert_hyp_gate_R3: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && (tgt_mode == M_HYP)) |-> ($past(hyp_on) || ($past(cur_mode) == M_HYP)));

  // R10: syndrome moves only together with a hypervisor entry
  assert_syn_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(syndrome) |-> (vec_valid && (tgt_mode == M_HYP)));

  // R11: every exception request yields a vector one clock later
  assert_latency_R11: assert property (@(posedge clk) disable iff (rst)
    ($past(exc_req) && !$past(rst)) |-> vec_valid);
endmodule

// File: tb/exc_vector_router_tb.sv
module exc_vector_router_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  cur_mode;
  logic        exc_req;
  logic [2:0]  exc_type;
  logic [15:0] hvc_imm;
  logic        trap_req;
  logic [5:0]  trap_ec;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic        hen_wr, hen_val;
  logic [1:0]  rd_sel;
  logic        vec_valid, access_fault, hyp_on;
  logic [2:0]  tgt_mode;
  logic [31:0] vec_addr, rd_base;
  logic [21:0] syndrome;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] m_base [3];
  logic        m_hyp;
  logic [21:0] m_syn;

  always #10 clk = ~clk;

  exc_vector_router u_dut (
    .clk(clk), .rst(rst), .cur_mode(cur_mode), .exc_req(exc_req),
    .exc_type(exc_type), .hvc_imm(hvc_imm), .trap_req(trap_req),
    .trap_ec(trap_ec), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .hen_wr(hen_wr), .hen_val(hen_val), .rd_sel(rd_sel),
    .vec_valid(vec_valid), .tgt_mode(tgt_mode), .vec_addr(vec_addr),
    .access_fault(access_fault), .syndrome(syndrome), .hyp_on(hyp_on),
    .rd_base(rd_base)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // context used for a given mode (R1, R2, R5)
  task automatic ctx(input logic [2:0] md, output logic [2:0] t, output logic [31:0] b);
    if (md == 3'd2) begin t = 3'd2; b = m_base[1]; end
    else if (md >= 3'd3) begin t = 3'd5; b = m_base[2]; end
    else begin t = 3'd1; b = m_base[0]; end
  endtask

  task automatic step(input string tag_in, input logic [2:0] md, input logic er,
                      input logic [2:0] et, input logic [15:0] imm, input logic tr,
                      input logic [5:0] tec, input logic we, input logic [1:0] ws,
                      input logic [31:0] wd, input logic hw, input logic hv,
                      input logic [1:0] rs);
    logic        legal, wbad, gh, e_valid, e_fault, sload;
    logic [2:0]  e_mode, slot;
    logic [31:0] e_addr, b, e_rd;
    logic [21:0] sval;
    string       tag;
    cur_mode = md; exc_req = er; exc_type = et; hvc_imm = imm; trap_req = tr;
    trap_ec = tec; wr_en = we; wr_sel = ws; wr_data = wd; hen_wr = hw;
    hen_val = hv; rd_sel = rs;

    case (ws)
      2'd0: legal = (md != 3'd0) && (md != 3'd3);
      2'd1: legal = (md == 3'd2) || (md == 3'd5);
      2'd2: legal = (md == 3'd5);
      default: legal = 1'b0;
    endcase
    wbad = we && !legal;
    gh = m_hyp && (md == 3'd1);
    e_valid = 1'b0; e_fault = 1'b0; sload = 1'b0; sval = '0;
    e_mode = 3'd0; e_addr = 32'd0; tag = "R1";
    if (er && et == 3'd0) begin
      e_valid = 1'b1; e_mode = 3'd5; e_addr = m_base[2]; tag = "R12";
    end else if (wbad) begin
      e_valid = 1'b1; e_fault = 1'b1; ctx(md, e_mode, b); e_addr = b + 32'h04; tag = "R8";
    end else if (er) begin
      e_valid = 1'b1;
      if (et == 3'd5 && gh) begin
        e_mode = 3'd2; e_addr = m_base[1] + 32'h14; sload = 1'b1;
        sval = {6'h12, imm}; tag = "R3";
      end else if (et == 3'd5 && md != 3'd2) begin
        ctx(md, e_mode, b); e_addr = b + 32'h04; tag = "R4";
      end else begin
        slot = et; ctx(md, e_mode, b); e_addr = b + {27'd0, slot, 2'b00};
        tag = (md == 3'd2) ? "R5" : (md >= 3'd3) ? "R2" : "R1";
      end
    end else if (tr && gh) begin
      e_valid = 1'b1; e_mode = 3'd2; e_addr = m_base[1] + 32'h14; sload = 1'b1;
      sval = {tec, 16'h0}; tag = "R7";
    end else if (tr) begin
      tag = "R7";
    end
    e_rd = (rs == 2'd3) ? 32'd0 : m_base[rs];
    if (we && legal) m_base[ws] = wd & ~32'h1f;
    if (hw && (md == 3'd4 || md == 3'd5)) m_hyp = hv;
    if (sload) m_syn = sval;
    if (tag_in != "") tag = tag_in;

    @(posedge clk);
    @(negedge clk);
    check({tag, " valid"}, 128'(vec_valid), 128'(e_valid));
    if (e_valid) begin
      check({tag, " mode"}, 128'(tgt_mode), 128'(e_mode));
      check({tag, " addr"}, 128'(vec_addr), 128'(e_addr));
    end
    check({tag, " fault"}, 128'(access_fault), 128'(e_fault));
    check({tag, " R10 syndrome"}, 128'(syndrome), 128'(m_syn));
    check({tag, " R6 hyp_on"}, 128'(hyp_on), 128'(m_hyp));
    check({tag, " R9 rd_base"}, 128'(rd_base), 128'(e_rd));
  endtask

  task automatic idle();
    step("", 3'd1, 0, 3'd0, 16'h0, 0, 6'h0, 0, 2'd0, 32'h0, 0, 0, 2'd3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    cur_mode = 3'd0; exc_req = 0; exc_type = 0; hvc_imm = 0; trap_req = 0;
    trap_ec = 0; wr_en = 0; wr_sel = 0; wr_data = 0; hen_wr = 0; hen_val = 0;
    rd_sel = 0;
    for (int i = 0; i < 3; i++) m_base[i] = 32'd0;
    m_hyp = 1'b0; m_syn = 22'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 reset valid", 128'(vec_valid), 128'(0));
    check("R11 reset addr", 128'(vec_addr), 128'(0));
    check("R6 reset hyp_on", 128'(hyp_on), 128'(0));
    check("R10 reset syndrome", 128'(syndrome), 128'(0));
    rst = 1'b0;
    @(negedge clk);

    // R6: enable from guest kernel is ignored
    step("R6", 3'd1, 0, 3'd0, 16'h0, 0, 6'h0, 0, 2'd0, 32'h0, 1, 1, 2'd3);
    // R4: hypervisor call with level disabled becomes undefined
    step("R4", 3'd1, 1, 3'd5, 16'h55aa, 0, 6'h0, 0, 2'd0, 32'h0, 0, 0, 2'd3);
    // R7: trap ignored while level disabled
    step("R7", 3'd1, 0, 3'd0, 16'h0, 1, 6'h03, 0, 2'd0, 32'h0, 0, 0, 2'd3);
    // R9: base writes from monitor with low bits set
    step("R9", 3'd5, 0, 3'd0, 16'h0, 0, 6'h0, 1, 2'd1, 32'h8000_1234, 0, 0, 2'd3);
    step("R9", 3'd5, 0, 3'd0, 16'h0, 0, 6'h0, 1, 2'd2, 32'h0000_f03f, 0, 0, 2'd1);
    check("R9 hyp base masked", 128'(rd_base), 128'(32'h8000_1220));
    step("R9", 3'd1, 0, 3'd0, 16'h0, 0, 6'h0, 1, 2'd0, 32'h4000_00ff, 0, 0, 2'd2);
    check("R9 mon base masked", 128'(rd_base), 128'(32'h0000_f020));
    // R6: enable from secure kernel
    step("R6", 3'd4, 0, 3'd0, 16'h0, 0, 6'h0, 0, 2'd0, 32'h0, 1, 1, 2'd0);
    // R3: hypervisor call from guest kernel
    step("R3", 3'd1, 1, 3'd5, 16'hbeef, 0, 6'h0, 0, 2'd0, 32'h0, 0, 0, 2'd3);
    check("R3 literal addr", 128'(vec_addr), 128'(32'h8000_1234));
    check("R3 literal syndrome", 128'(syndrome), 128'({6'h12, 16'hbeef}));
    // R4: hypervisor call from guest user
    step("R4", 3'd0, 1, 3'd5, 16'h1111, 0, 6'h0, 0, 2'd0, 32'h0, 0, 0, 2'd3);
    // R7: trap taken
    step("R7", 3'd1, 0, 3'd0, 16'h0, 1, 6'h2c, 0, 2'd0, 32'h0, 0, 0, 2'd3);
    // R5: IRQ while in hypervisor mode, syndrome held (R10)
    step("R5", 3'd2, 1, 3'd6, 16'h0, 0, 6'h0, 0, 2'd0, 32'h0, 0, 0, 2'd3);
    // R8: hypervisor base write from guest kernel faults
    step("R8", 3'd1, 0, 3'd0, 16'h0, 0, 6'h0, 1, 2'd1, 32'hdead_0000, 0, 0, 2'd1);
    // R8: select 3 from monitor faults
    step("R8", 3'd5, 0, 3'd0, 16'h0, 0, 6'h0, 1, 2'd3, 32'h1, 0, 0, 2'd1);
    // R12: fault beats FIQ; reset type beats fault
    step("R12", 3'd0, 1, 3'd7, 16'h0, 0, 6'h0, 1, 2'd0, 32'h1, 0, 0, 2'd3);
    step("R12", 3'd0, 1, 3'd0, 16'h0, 0, 6'h0, 1, 2'd2, 32'h1, 0, 0, 2'd3);
    // R12: exception beats trap
    step("R12", 3'd1, 1, 3'd2, 16'h0, 1, 6'h07, 0, 2'd0, 32'h0, 0, 0, 2'd3);
    // R2: secure user prefetch abort
    step("R2", 3'd3, 1, 3'd3, 16'h0, 0, 6'h0, 0, 2'd0, 32'h0, 0, 0, 2'd3);
    idle();

    for (int n = 0; n < 3000; n++) begin
      logic [2:0] md;
      md = 3'($urandom_range(0, 5));
      if (md == 3'd2 && !m_hyp) md = 3'd1;
      step("", md, ($urandom_range(0, 1) == 1), 3'($urandom_range(0, 7)),
           16'($urandom), ($urandom_range(0, 2) == 0), 6'($urandom),
           ($urandom_range(0, 3) == 0), 2'($urandom_range(0, 3)), $urandom,
           ($urandom_range(0, 9) == 0), ($urandom_range(0, 3) != 0),
           2'($urandom_range(0, 3)));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule